// File: doc/BRIEF.md
# Retriggerable Standby Wakeup Controller

This block keeps the decoding logic behind a low-power receiver active only while data is arriving. Each detected transition of the demodulated input reaches the block as a one-cycle trigger pulse. A trigger loads a standby down counter with its largest value and starts a slow tick that stands in for the on-chip oscillator. Each tick lowers the count by one. The wakeup output stays high until the count reaches zero. A steady data stream keeps reloading the counter, so the block stays awake while the stream lasts.

The slow oscillator is modelled as a clock enable divided down from the free-running system clock. The division ratio is a parameter, so a bench can shorten the timeout. With the default count width and division, the timeout is about one second at 125 MHz. While the block is asleep, the tick divider is held and the count stays at zero. Downstream data passes through the block and is forced to zero whenever wakeup is low. Any logic that consumes it is therefore idle during sleep.

Top module: `wk_standby_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sets `awake_o` to 0, `count_o` to 0 and `data_o` to 0 at the next rising clock edge.
- R2: A trigger sampled high at a clock edge makes `awake_o` 1 from that edge onward.
- R3: While asleep with no trigger, `count_o` stays at 0 and does not move.
- R4: While awake, `count_o` decreases by exactly one every `OSC_DIV` clock cycles. The first decrement happens `OSC_DIV` cycles after the trigger edge.
- R5: A trigger loads `count_o` with all ones (1023 for the 10-bit default) and restarts the tick divider.
- R6: With no further trigger, `awake_o` falls at the edge where `count_o` reaches 0, which is (2^CNT_W − 1)·OSC_DIV cycles after the trigger edge.
- R7: A trigger while awake reloads the count, so the timeout is measured from the latest trigger.
- R8: A trigger in the same cycle as the tick that would reach zero takes priority. `awake_o` stays 1 and `count_o` becomes all ones.
- R9: `data_o` equals `data_i` while `awake_o` is 1, and is all zeros while `awake_o` is 0.
- R10: `rst` takes priority over a simultaneous trigger, so the block ends in the sleep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| trig_i | input | 1 | One-cycle wakeup trigger, one per input transition |
| data_i | input | DATA_W | Data from the demodulator toward the decoding logic |
| awake_o | output | 1 | High while the block is awake |
| count_o | output | CNT_W | Current standby count |
| data_o | output | DATA_W | Data gated by the wakeup state |

## Verification
A wrong reload value or a wrong tick period shows up on `count_o` right after a trigger. It also shifts the falling edge of `awake_o`, so the bench checks the cycles just before and at the expected expiry edge. A lost trigger priority makes `awake_o` drop exactly at the coincident edge, and `count_o` reads 0 instead of all ones one cycle later. A gate that ignores the sleep state shows on `data_o` in the first cycle after expiry or reset.

// File: rtl/wk_pkg.sv
package wk_pkg;

    typedef enum logic {
        WK_SLEEP = 1'b0,
        WK_RUN   = 1'b1
    } wk_state_e;

    localparam int WK_CNT_W_DEF  = 10;
    localparam int WK_DIV_DEF    = 122070;
    localparam int WK_DATA_W_DEF = 8;

    function automatic int wk_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wk_prescale.sv
module wk_prescale #(
    parameter int DIV = wk_pkg::WK_DIV_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = wk_pkg::wk_width(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    generate
        if (DIV == 1) begin : g_direct
            assign pre_q = '0;
            assign tick  = run && !restart;
        end else begin : g_div
            always_ff @(posedge clk) begin
                if (rst || restart || !run) begin
                    pre_q <= '0;
                end else if (pre_q == LAST) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
            assign tick = run && !restart && (pre_q == LAST);
        end
    endgenerate

    // R4
    pre_range_chk: assert property (@(posedge clk) disable iff (rst)
        pre_q <= LAST);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> (pre_q == '0));

endmodule

// File: rtl/wk_downcnt.sv
module wk_downcnt
    import wk_pkg::*;
#(
    parameter int W = wk_pkg::WK_CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         tick,
    output logic [W-1:0] count,
    output wk_state_e    state
);
    localparam logic [W-1:0] FULL = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            state <= WK_SLEEP;
        end else if (load) begin
            count <= FULL;
            state <= WK_RUN;
        end else if (state == WK_RUN && tick) begin
            count <= count - 1'b1;
            if (count == ONE) begin
                state <= WK_SLEEP;
            end
        end
    end

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == FULL && state == WK_RUN));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && state == WK_RUN && tick) |=> (count == $past(count) - 1'b1));

    // R3
    sleep_still_chk: assert property (@(posedge clk) disable iff (rst)
        (state == WK_SLEEP && !load) |=> (count == '0 && $stable(count)));

    // R6
    expire_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state == WK_RUN && $past(state) == WK_RUN && $past(!load)) |-> (count != '0));

endmodule

// File: rtl/wk_gate.sv
module wk_gate #(
    parameter int DW = wk_pkg::WK_DATA_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          awake,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    always_comb begin
        dout = awake ? din : '0;
    end

    // R9
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !awake |-> (dout == '0));

endmodule

// File: rtl/wk_standby_ctrl.sv
module wk_standby_ctrl
    import wk_pkg::*;
#(
    parameter int CNT_W   = wk_pkg::WK_CNT_W_DEF,
    parameter int OSC_DIV = wk_pkg::WK_DIV_DEF,
    parameter int DATA_W  = wk_pkg::WK_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              awake_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [DATA_W-1:0] data_o
);
    wk_state_e st;
    logic      tick;
    logic      run;

    assign run     = (st == WK_RUN);
    assign awake_o = run;

    wk_prescale #(.DIV(OSC_DIV)) i_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (trig_i),
        .tick    (tick)
    );

    wk_downcnt #(.W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (trig_i),
        .tick  (tick),
        .count (count_o),
        .state (st)
    );

    wk_gate #(.DW(DATA_W)) i_gate (
        .clk   (clk),
        .rst   (rst),
        .awake (awake_o),
        .din   (data_i),
        .dout  (data_o)
    );

    // R2
    wake_rise_chk: assert property (@(posedge clk) disable iff (rst)
        trig_i |=> awake_o);

    // R6
    fall_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(awake_o) |-> (count_o == '0));

    // R1
    reset_sleep_chk: assert property (@(posedge clk)
        rst |=> (!awake_o && count_o == '0));

endmodule

// File: tb/test_wk_standby_ctrl.sv
module test_wk_standby_ctrl;
    localparam int CW  = 10;
    localparam int DIV = 3;
    localparam int DW  = 8;
    localparam int FULL = (1 << CW) - 1;
    localparam int TOUT = FULL * DIV;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig = 1'b0;
    logic [DW-1:0] din = 8'hA5;
    logic          awake;
    logic [CW-1:0] cnt;
    logic [DW-1:0] dout;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wk_standby_ctrl #(.CNT_W(CW), .OSC_DIV(DIV), .DATA_W(DW)) i_wk_standby_ctrl (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (trig),
        .data_i  (din),
        .awake_o (awake),
        .count_o (cnt),
        .data_o  (dout)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; din = 8'h3C;
        wait_n(2);
        chk("R1 awake", int'(awake), 0);
        chk("R1 count", int'(cnt), 0);
        chk("R1 data", int'(dout), 0);
        rst = 1'b0;
        wait_n(5);
        chk("R3 count idle", int'(cnt), 0);
        chk("R9 data asleep", int'(dout), 0);
    endtask

    task automatic t_single();
        din = 8'h5A;
        pulse();
        chk("R2 awake", int'(awake), 1);
        chk("R5 reload", int'(cnt), FULL);
        chk("R9 pass", int'(dout), 8'h5A);
        din = 8'hC3;
        #1 chk("R9 pass second", int'(dout), 8'hC3);
        wait_n(DIV - 1);
        chk("R4 before tick", int'(cnt), FULL);
        wait_n(1);
        chk("R4 first tick", int'(cnt), FULL - 1);
        wait_n(TOUT - DIV - 1);
        chk("R6 still awake", int'(awake), 1);
        chk("R6 count one", int'(cnt), 1);
        wait_n(1);
        chk("R6 expired", int'(awake), 0);
        chk("R6 count zero", int'(cnt), 0);
        chk("R9 gated", int'(dout), 0);
        wait_n(4 * DIV);
        chk("R3 stays zero", int'(cnt), 0);
        chk("R3 stays asleep", int'(awake), 0);
    endtask

    task automatic t_retrigger();
        pulse();
        wait_n(500 * DIV);
        chk("R4 after 500 ticks", int'(cnt), FULL - 500);
        pulse();
        chk("R7 reload", int'(cnt), FULL);
        wait_n(TOUT - 1);
        chk("R7 awake from new trigger", int'(awake), 1);
        wait_n(1);
        chk("R7 expiry", int'(awake), 0);
    endtask

    task automatic t_coincident();
        pulse();
        wait_n(TOUT - 1);
        chk("R8 count one", int'(cnt), 1);
        pulse();
        chk("R8 awake kept", int'(awake), 1);
        chk("R8 reloaded", int'(cnt), FULL);
        wait_n(DIV);
        chk("R8 ticking", int'(cnt), FULL - 1);
    endtask

    task automatic t_reset_priority();
        rst = 1'b1; trig = 1'b1;
        wait_n(1);
        rst = 1'b0; trig = 1'b0;
        chk("R10 asleep", int'(awake), 0);
        chk("R10 count", int'(cnt), 0);
        wait_n(3);
        chk("R10 stays asleep", int'(awake), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_retrigger();
        t_coincident();
        t_reset_priority();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule